// File: doc/BRIEF.md
# Banked Data Register File with Shared Low Window

This block holds the 8-bit data registers of a small controller core. An instruction names a register with a 5-bit field, which gives a 32-slot window. A pointer register decides which of eight banks that window looks into. Its top three bits give the bank number, and all eight bits serve as an address for indirect access.

The lower 16 slots of the window are common to every bank. Slot 0 is the indirect port. Slot 4 is the pointer register itself. Slots 1–3 and 5–7 belong to neighbouring logic outside the block and are reached through an external strobe and an external read bus. Slots 8–15 are shared storage.

The upper 16 slots are private to the selected bank. In bank n they occupy physical addresses n·32+16 to n·32+31. A write is clocked, and a read is combinational.

Top module: `banked_regfile`

## Requirements
- R1: After rst_ni is asserted, the pointer register and all shared and private storage read as 0.
- R2: Direct slots 0x08–0x0F reach the same eight registers whatever bank the pointer selects.
- R3: Direct slots 0x10–0x1F reach physical address {pointer[7:5], slot}, so each bank's upper half is isolated from every other bank's.
- R4: A write to slot 0x04 loads the pointer on that clock edge, and fsr_o shows the new value from then on. A read of slot 0x04 returns the pointer. The new bank applies to reads from the cycle after the edge.
- R5: Slot 0x00 uses the full 8-bit pointer value as a physical address P. If P[4]=1, the access reaches private bank P[7:5], entry P[3:0]. If P[4]=0, it reaches the common slot P[4:0], exactly as a direct access to that slot would.
- R6: If the physical address reached through slot 0x00 has P[4:0]=0, a read returns 0 and a write changes nothing.
- R7: A write whose resolved common slot is 1–3 or 5–7 raises ext_we_o in the same cycle, with ext_wr_idx_o set to that slot number, and stores nothing internally. For all other writes, ext_we_o is 0.
- R8: A read whose resolved common slot is 1–3 or 5–7 returns ext_rdata_i, and ext_rd_idx_o carries that slot number. Otherwise ext_rd_idx_o is 0.
- R9: A read is combinational. A read of the slot being written returns the old value until the clock edge and the new value after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write enable |
| wr_fr_i | input | 5 | Write slot within the window |
| wdata_i | input | 8 | Write data |
| rd_fr_i | input | 5 | Read slot within the window |
| rdata_o | output | 8 | Read data (combinational) |
| fsr_o | output | 8 | Current pointer/bank register value |
| ext_we_o | output | 1 | Write strobe for external dedicated registers |
| ext_wr_idx_o | output | 3 | Slot number of the external write |
| ext_rd_idx_o | output | 3 | Slot number of the external read, 0 when none |
| ext_rdata_i | input | 8 | Read data from external dedicated registers |

## Verification
A wrong pointer value shows on fsr_o at the edge after the write. It also shows at the next combinational read of an upper-half slot or of slot 0, which then returns data from the wrong bank. A bank-decode fault that lets one bank's write land in another bank stays hidden until that other bank is selected and read. For this reason, every bank is written first and then read back in turn. Aliasing faults in the shared half appear when a value written under one bank is read under another, both directly and through the indirect port.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;
  localparam int FR_W   = 5;
  localparam int BANK_W = 3;
  localparam int PA_W   = FR_W + BANK_W;
  localparam int SLOT_W = FR_W - 1;
  localparam int DED_W  = FR_W - 2;
  localparam int BANKS  = 2 ** BANK_W;
  localparam int SH_N   = 2 ** DED_W;
  localparam int PV_N   = 2 ** SLOT_W;
  localparam logic [FR_W-1:0]  IND_FR   = '0;
  localparam logic [DED_W-1:0] NULL_SLOT = '0;
  localparam logic [DED_W-1:0] PTR_SLOT  = DED_W'(4);

  typedef enum logic [2:0] {
    TGT_NULL, TGT_FSR, TGT_EXT, TGT_SHARED, TGT_PRIV
  } tgt_e;

  typedef struct packed {
    tgt_e              kind;
    logic [BANK_W-1:0] bank;
    logic [SLOT_W-1:0] idx;
  } tgt_t;
endpackage

// File: rtl/brf_xlate.sv
module brf_xlate
  import banked_rf_pkg::*;
(
  input  logic [FR_W-1:0] fr_i,
  input  logic [PA_W-1:0] fsr_i,
  output tgt_t            tgt_o
);
  logic [PA_W-1:0] phys;

  always_comb begin
    if (fr_i == IND_FR)       phys = fsr_i;
    else if (fr_i[FR_W-1])    phys = {fsr_i[PA_W-1 -: BANK_W], fr_i};
    else                      phys = {{BANK_W{1'b0}}, fr_i};

    tgt_o.bank = phys[PA_W-1 -: BANK_W];
    tgt_o.idx  = phys[SLOT_W-1:0];
    if (phys[FR_W-1])                         tgt_o.kind = TGT_PRIV;
    else if (phys[DED_W])                     tgt_o.kind = TGT_SHARED;
    else if (phys[DED_W-1:0] == NULL_SLOT)    tgt_o.kind = TGT_NULL;
    else if (phys[DED_W-1:0] == PTR_SLOT)     tgt_o.kind = TGT_FSR;
    else                                      tgt_o.kind = TGT_EXT;
  end
endmodule

// File: rtl/brf_shared_store.sv
module brf_shared_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/brf_priv_store.sv
module brf_priv_store #(
  parameter int DATA_W = 8,
  parameter int BANKS  = 8,
  parameter int DEPTH  = 16,
  localparam int BNK_W = $clog2(BANKS),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [BNK_W-1:0]  wbank_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BNK_W-1:0]  rbank_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] bank_rd [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              sel;

    assign sel = we_i && (wbank_i == BNK_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (sel) begin
        mem_q[widx_i] <= wdata_i;
      end
    end

    assign bank_rd[b] = mem_q[ridx_i];
  end

  assign rdata_o = bank_rd[rbank_i];
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_rf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [FR_W-1:0]   wr_fr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [FR_W-1:0]   rd_fr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [PA_W-1:0]   fsr_o,
  output logic              ext_we_o,
  output logic [DED_W-1:0]  ext_wr_idx_o,
  output logic [DED_W-1:0]  ext_rd_idx_o,
  input  logic [DATA_W-1:0] ext_rdata_i
);
  logic [PA_W-1:0]   fsr_q;
  tgt_t              wr_tgt, rd_tgt;
  logic [DATA_W-1:0] sh_rdata, pv_rdata;
  logic              sh_we, pv_we, fsr_we;

  brf_xlate u_wr_xlate (.fr_i(wr_fr_i), .fsr_i(fsr_q), .tgt_o(wr_tgt));
  brf_xlate u_rd_xlate (.fr_i(rd_fr_i), .fsr_i(fsr_q), .tgt_o(rd_tgt));

  assign sh_we    = we_i && (wr_tgt.kind == TGT_SHARED);
  assign pv_we    = we_i && (wr_tgt.kind == TGT_PRIV);
  assign fsr_we   = we_i && (wr_tgt.kind == TGT_FSR);
  assign ext_we_o = we_i && (wr_tgt.kind == TGT_EXT);
  assign ext_wr_idx_o = ext_we_o ? wr_tgt.idx[DED_W-1:0] : '0;
  assign ext_rd_idx_o = (rd_tgt.kind == TGT_EXT) ? rd_tgt.idx[DED_W-1:0] : '0;

  // Pointer doubles as bank select; new bank is seen by the xlates next cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fsr_q <= '0;
    else if (fsr_we) fsr_q <= PA_W'(wdata_i);
  end
  assign fsr_o = fsr_q;

  brf_shared_store #(.DATA_W(DATA_W), .DEPTH(SH_N)) u_shared (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (sh_we),
    .widx_i (wr_tgt.idx[DED_W-1:0]),
    .wdata_i(wdata_i),
    .ridx_i (rd_tgt.idx[DED_W-1:0]),
    .rdata_o(sh_rdata)
  );

  brf_priv_store #(.DATA_W(DATA_W), .BANKS(BANKS), .DEPTH(PV_N)) u_priv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (pv_we),
    .wbank_i(wr_tgt.bank),
    .widx_i (wr_tgt.idx),
    .wdata_i(wdata_i),
    .rbank_i(rd_tgt.bank),
    .ridx_i (rd_tgt.idx),
    .rdata_o(pv_rdata)
  );

  always_comb begin
    unique case (rd_tgt.kind)
      TGT_FSR:    rdata_o = DATA_W'(fsr_q);
      TGT_EXT:    rdata_o = ext_rdata_i;
      TGT_SHARED: rdata_o = sh_rdata;
      TGT_PRIV:   rdata_o = pv_rdata;
      default:    rdata_o = '0;
    endcase
  end

  AST_FSR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsr_we |=> fsr_o == PA_W'($past(wdata_i))); // R4
  AST_FSR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fsr_we |=> $stable(fsr_o)); // R4
  AST_NULL_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_tgt.kind == TGT_NULL) |-> rdata_o == '0); // R6
  AST_EXT_READ_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_tgt.kind == TGT_EXT) |-> rdata_o == ext_rdata_i); // R8
  AST_EXT_WR_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_we_o |-> (ext_wr_idx_o != NULL_SLOT && ext_wr_idx_o != PTR_SLOT)); // R7
  AST_WR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sh_we, pv_we, fsr_we, ext_we_o})); // R7
endmodule

// File: tb/banked_regfile_tb_top.sv
`timescale 1ns/1ps
module banked_regfile_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [4:0] wr_fr = '0;
  logic [7:0] wdata = '0;
  logic [4:0] rd_fr = '0;
  logic [7:0] rdata, fsr, ext_rdata;
  logic       ext_we;
  logic [2:0] ext_wr_idx, ext_rd_idx;

  int checks = 0;
  int fails  = 0;

  logic [7:0] m_mem [256];
  logic [7:0] m_fsr;

  always #2 clk = ~clk;

  assign ext_rdata = {5'b10100, ext_rd_idx};

  banked_regfile dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .wr_fr_i(wr_fr), .wdata_i(wdata),
    .rd_fr_i(rd_fr), .rdata_o(rdata), .fsr_o(fsr), .ext_we_o(ext_we),
    .ext_wr_idx_o(ext_wr_idx), .ext_rd_idx_o(ext_rd_idx), .ext_rdata_i(ext_rdata)
  );

  // op(1=write) | slot | data
  localparam int NV = 32;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 5'h08, 8'h11}, {1'b1, 5'h0F, 8'h22}, {1'b1, 5'h04, 8'h20},
    {1'b0, 5'h08, 8'h00}, {1'b1, 5'h10, 8'h33}, {1'b1, 5'h1F, 8'h44},
    {1'b1, 5'h04, 8'hE0}, {1'b0, 5'h10, 8'h00}, {1'b1, 5'h10, 8'h55},
    {1'b0, 5'h0F, 8'h00}, {1'b1, 5'h04, 8'h30}, {1'b0, 5'h00, 8'h00},
    {1'b0, 5'h10, 8'h00}, {1'b1, 5'h00, 8'h66}, {1'b0, 5'h10, 8'h00},
    {1'b1, 5'h04, 8'h08}, {1'b0, 5'h00, 8'h00}, {1'b1, 5'h04, 8'hEF},
    {1'b0, 5'h00, 8'h00}, {1'b1, 5'h04, 8'hF0}, {1'b0, 5'h00, 8'h00},
    {1'b1, 5'h04, 8'h40}, {1'b0, 5'h00, 8'h00}, {1'b1, 5'h00, 8'h77},
    {1'b0, 5'h00, 8'h00}, {1'b1, 5'h04, 8'h44}, {1'b0, 5'h00, 8'h00},
    {1'b0, 5'h05, 8'h00}, {1'b1, 5'h06, 8'h99}, {1'b1, 5'h02, 8'h3C},
    {1'b0, 5'h03, 8'h00}, {1'b0, 5'h1F, 8'h00}
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] phys_of(input logic [4:0] fr);
    if (fr == 5'd0) return m_fsr;
    if (fr[4])      return {m_fsr[7:5], fr};
    return {3'b000, fr};
  endfunction

  function automatic logic [7:0] canon(input logic [7:0] pa);
    return pa[4] ? pa : {3'b000, pa[4:0]};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 256; i++) m_mem[i] = '0;
    m_fsr = '0;
  endtask

  task automatic do_read(input logic [4:0] fr);
    logic [7:0] pa, exp;
    logic [4:0] lo;
    string req;
    pa = phys_of(fr);
    lo = pa[4:0];
    if (lo == 5'd0)      begin exp = 8'h00; req = "R6"; end
    else if (lo == 5'd4) begin exp = m_fsr; req = "R4"; end
    else if (lo < 5'd8)  begin exp = {5'b10100, lo[2:0]}; req = "R8"; end
    else begin
      exp = m_mem[canon(pa)];
      req = lo[4] ? "R3" : "R2";
    end
    if (fr == 5'd0 && lo != 5'd0) req = "R5";
    @(negedge clk);
    rd_fr = fr;
    #1;
    check(rdata, exp, req);
    if (lo != 5'd0 && lo < 5'd8 && lo != 5'd4)
      check({5'b0, ext_rd_idx}, {5'b0, lo[2:0]}, "R8");
  endtask

  task automatic do_write(input logic [4:0] fr, input logic [7:0] d);
    logic [7:0] pa;
    logic [4:0] lo;
    logic       ded;
    pa = phys_of(fr);
    lo = pa[4:0];
    ded = (lo != 5'd0) && (lo < 5'd8) && (lo != 5'd4);
    @(negedge clk);
    we = 1'b1; wr_fr = fr; wdata = d;
    #1;
    check({7'b0, ext_we}, {7'b0, ded}, "R7");
    if (ded) check({5'b0, ext_wr_idx}, {5'b0, lo[2:0]}, "R7");
    @(posedge clk);
    #1;
    we = 1'b0;
    if (lo == 5'd4) begin
      m_fsr = d;
      check(fsr, m_fsr, "R4");
    end else if (lo >= 5'd8) begin
      m_mem[canon(pa)] = d;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check(fsr, 8'h00, "R1");
    do_read(5'h08);
    do_read(5'h10);
    do_read(5'h1F);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][13]) do_write(VEC[i][12:8], VEC[i][7:0]);
      else            do_read(VEC[i][12:8]);
    end

    // R3 isolation, R2 aliasing across all banks
    for (int b = 0; b < 8; b++) begin
      do_write(5'h04, 8'(b << 5));
      do_write(5'h1A, 8'(8'h80 + b));
      do_write(5'h09, 8'(8'hC0 + b));
    end
    for (int b = 0; b < 8; b++) begin
      do_write(5'h04, 8'(b << 5));
      do_read(5'h1A);
      do_read(5'h09);
      do_write(5'h04, 8'((b << 5) | 8'h1A));
      do_read(5'h00); // R5: indirect equals direct
    end

    // R9: read during write
    do_write(5'h04, 8'h00);
    @(negedge clk);
    rd_fr = 5'h0A; we = 1'b1; wr_fr = 5'h0A; wdata = 8'h5C;
    #1; check(rdata, m_mem[8'h0A], "R9");
    @(posedge clk); #1;
    check(rdata, 8'h5C, "R9");
    we = 1'b0; m_mem[8'h0A] = 8'h5C;

    // R4: bank switch takes effect after the edge
    do_write(5'h10, 8'hB0);
    do_write(5'h04, 8'h20);
    @(negedge clk);
    rd_fr = 5'h10; we = 1'b1; wr_fr = 5'h04; wdata = 8'h00;
    #1; check(rdata, m_mem[8'h30], "R4");
    @(posedge clk); #1;
    check(rdata, 8'hB0, "R4");
    check(fsr, 8'h00, "R4");
    we = 1'b0; m_fsr = 8'h00;

    // R1: reset clears storage after use
    @(negedge clk);
    rst_n = 1'b0;
    #1; rst_n = 1'b1;
    model_reset();
    check(fsr, 8'h00, "R1");
    do_read(5'h0A);
    do_read(5'h10);
    do_write(5'h04, 8'hE0);
    do_read(5'h10);

    finish_run();
  end
endmodule